// File: doc/BRIEF.md
# Cache Miss Fill Sequencer

This block handles one miss at a time for a set-associative copyback data cache that allocates on writes. When the cache controller reports a miss, it hands over the missing address, the way picked for replacement, and that way's valid bit, dirty bit and tag. If the victim holds modified data, the sequencer first reads the victim's sixteen words out of the data array and writes them to memory. It then fetches the new 64-byte block over a word-wide memory port. The fetch starts at the word the requester asked for and wraps around the block. Every returned word is written into the data array. The requested word is also handed back to the requester as soon as it arrives. When all sixteen words are in, the sequencer issues a single tag update with the new tag and the valid bit. The dirty bit is set when the miss was a store.

A programmable address window, set by a base input and a limit input, marks memory that must not be cached. A request that falls inside it becomes a single uncached word access on the memory port. It touches neither the data array nor the tag array. The data array, the tag array and the replacement choice are outside this block.

Top module: `miss_fill_seq`

## Requirements
- R1: After reset, `busy`, `mem_req_valid`, `rsp_valid`, `arr_wr_en` and `tag_wr_en` are all low.
- R2: A request is taken when `req_valid` is high while `busy` is low. `busy` then stays high until the cycle after the tag update pulse (or the end of an uncached access). `req_valid` has no effect while `busy` is high.
- R3: When the victim is both valid and dirty, sixteen memory writes are issued, for victim words 0 to 15 in ascending order, at address {victim_tag, set, word, 2'b00}. Each write carries the data the array returned for that word. All sixteen writes come before the first fill read.
- R4: When the victim is invalid, or valid but clean, no memory write is issued for it.
- R5: The fill issues sixteen reads. Read i (i = 0..15) fetches word w = (c + i) mod 16, where c = address bits 5..2, at address {addr[31:11], addr[10:6], w, 2'b00}. Each response is written to array word w, at set addr[10:6] and at the victim way.
- R6: For each cached miss, `rsp_valid` pulses exactly once, one cycle after the critical word (i = 0) arrives. `rsp_data` then carries that word as written into the array.
- R7: For a store miss, byte lane k (bits 8k+7..8k) of the critical word is taken from `req_wdata` where `req_be[k]` is 1 and from memory otherwise.
- R8: After the sixteenth fill word, `tag_wr_en` pulses for one cycle. It carries tag addr[31:11], and `tag_wr_dirty` equals the store flag of the request.
- R9: A request whose word-aligned address A satisfies `nc_base` <= A < `nc_limit` (unsigned) makes exactly one memory access at A and causes no array or tag write. A load returns the memory word on `rsp_valid`. A store carries `req_wdata` and `req_be`, and `rsp_valid` then pulses with data 0 one cycle after the handshake.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays asserted on the next cycle with unchanged address, direction and data.
- R11: Address bits 1..0 are ignored: all memory addresses are word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Miss or uncached request |
| req_addr | input | 32 | Byte address of the access |
| req_write | input | 1 | 1 for a store |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| victim_way | input | 3 | Way to be replaced |
| victim_valid | input | 1 | Victim block holds valid data |
| victim_dirty | input | 1 | Victim block is modified |
| victim_tag | input | 21 | Tag of the victim block |
| nc_base | input | 32 | First address of the uncached window |
| nc_limit | input | 32 | First address past the uncached window |
| busy | output | 1 | Request in progress |
| rsp_valid | output | 1 | Requester data pulse |
| rsp_data | output | 32 | Requester data |
| arr_set | output | 5 | Data array set index |
| arr_way | output | 3 | Data array way |
| arr_rd_en | output | 1 | Data array read, data one cycle later |
| arr_rd_word | output | 4 | Word read from the array |
| arr_rd_data | input | 32 | Array read data |
| arr_wr_en | output | 1 | Data array write |
| arr_wr_word | output | 4 | Word written to the array |
| arr_wr_data | output | 32 | Array write data |
| tag_wr_en | output | 1 | Tag update: valid set, new tag |
| tag_wr_tag | output | 21 | New tag |
| tag_wr_dirty | output | 1 | New dirty bit |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_addr | output | 32 | Memory word address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_req_be | output | 4 | Memory byte enables |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 32 | Memory read data |

## Verification
Cached misses are run with critical words 0, 5, 9 and 15. These separate a correct modulo wrap from a fill that restarts at word 0 or stops at the block end. Victims are given as clean, as dirty-and-valid and as dirty-but-invalid. This shows whether the write-back decision uses both bits, and whether every victim write precedes the fill. Stores use sparse byte enables on an unaligned address, so a wrong byte lane or an unmasked address low part shows up in the array data and in the response. Accesses at the window base, just under the limit and exactly at the limit expose off-by-one errors in the window compare. A slow memory-ready pattern and a request pulse sent while busy test request holding and the ignoring of new requests.

// File: rtl/miss_fill_seq.sv
module miss_fill_seq #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int WORDS = 16,
  parameter int WAYS  = 8,
  parameter int SETS  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [AW-1:0]             req_addr,
  input  logic                      req_write,
  input  logic [DW-1:0]             req_wdata,
  input  logic [DW/8-1:0]           req_be,
  input  logic [$clog2(WAYS)-1:0]   victim_way,
  input  logic                      victim_valid,
  input  logic                      victim_dirty,
  input  logic [AW-$clog2(SETS)-$clog2(WORDS)-$clog2(DW/8)-1:0] victim_tag,
  input  logic [AW-1:0]             nc_base,
  input  logic [AW-1:0]             nc_limit,
  output logic                      busy,
  output logic                      rsp_valid,
  output logic [DW-1:0]             rsp_data,
  output logic [$clog2(SETS)-1:0]   arr_set,
  output logic [$clog2(WAYS)-1:0]   arr_way,
  output logic                      arr_rd_en,
  output logic [$clog2(WORDS)-1:0]  arr_rd_word,
  input  logic [DW-1:0]             arr_rd_data,
  output logic                      arr_wr_en,
  output logic [$clog2(WORDS)-1:0]  arr_wr_word,
  output logic [DW-1:0]             arr_wr_data,
  output logic                      tag_wr_en,
  output logic [AW-$clog2(SETS)-$clog2(WORDS)-$clog2(DW/8)-1:0] tag_wr_tag,
  output logic                      tag_wr_dirty,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic                      mem_req_write,
  output logic [AW-1:0]             mem_req_addr,
  output logic [DW-1:0]             mem_req_wdata,
  output logic [DW/8-1:0]           mem_req_be,
  input  logic                      mem_rsp_valid,
  input  logic [DW-1:0]             mem_rsp_data
);

  localparam int BEW  = DW / 8;
  localparam int OFFW = $clog2(BEW);
  localparam int WW   = $clog2(WORDS);
  localparam int SW   = $clog2(SETS);
  localparam int WYW  = $clog2(WAYS);
  localparam int TW   = AW - SW - WW - OFFW;
  localparam logic [WW-1:0] LAST = WW'(WORDS - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_WB_RD, S_WB_LAT, S_WB_SEND, S_F_REQ, S_F_WAIT, S_TAG, S_U_REQ, S_U_WAIT
  } state_t;

  state_t          state;
  logic [AW-1:0]   addr_q;
  logic            wr_q;
  logic [DW-1:0]   wdata_q;
  logic [BEW-1:0]  be_q;
  logic [WYW-1:0]  way_q;
  logic [TW-1:0]   vtag_q;
  logic [WW-1:0]   cnt_q;
  logic [DW-1:0]   wb_buf;

  function automatic logic [DW-1:0] merge_bytes(input logic [DW-1:0] mem_w,
                                                input logic [DW-1:0] st_w,
                                                input logic [BEW-1:0] en);
    logic [DW-1:0] r;
    r = mem_w;
    for (int b = 0; b < BEW; b++)
      if (en[b]) r[8*b +: 8] = st_w[8*b +: 8];
    return r;
  endfunction

  logic [AW-1:0] req_al;
  logic          in_window;
  logic [TW-1:0] tag_q;
  logic [SW-1:0] set_q;
  logic [WW-1:0] crit_q;
  logic [WW-1:0] fill_word;

  assign req_al    = {req_addr[AW-1:OFFW], {OFFW{1'b0}}};
  assign in_window = (req_al >= nc_base) && (req_al < nc_limit);
  assign tag_q     = addr_q[AW-1 -: TW];
  assign set_q     = addr_q[OFFW+WW +: SW];
  assign crit_q    = addr_q[OFFW +: WW];
  assign fill_word = crit_q + cnt_q;

  assign busy         = (state != S_IDLE);
  assign arr_set      = set_q;
  assign arr_way      = way_q;
  assign arr_rd_en    = (state == S_WB_RD);
  assign arr_rd_word  = cnt_q;
  assign arr_wr_en    = (state == S_F_WAIT) && mem_rsp_valid;
  assign arr_wr_word  = fill_word;
  assign arr_wr_data  = (wr_q && cnt_q == '0) ? merge_bytes(mem_rsp_data, wdata_q, be_q)
                                              : mem_rsp_data;
  assign tag_wr_en    = (state == S_TAG);
  assign tag_wr_tag   = tag_q;
  assign tag_wr_dirty = wr_q;

  assign mem_req_valid = (state == S_WB_SEND) || (state == S_F_REQ) || (state == S_U_REQ);
  assign mem_req_write = (state == S_WB_SEND) || ((state == S_U_REQ) && wr_q);
  assign mem_req_wdata = (state == S_WB_SEND) ? wb_buf : wdata_q;
  assign mem_req_be    = (state == S_U_REQ && wr_q) ? be_q : {BEW{1'b1}};

  always_comb begin
    case (state)
      S_WB_SEND: mem_req_addr = {vtag_q, set_q, cnt_q, {OFFW{1'b0}}};
      S_F_REQ:   mem_req_addr = {tag_q, set_q, fill_word, {OFFW{1'b0}}};
      default:   mem_req_addr = addr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      addr_q    <= '0;
      wr_q      <= 1'b0;
      wdata_q   <= '0;
      be_q      <= '0;
      way_q     <= '0;
      vtag_q    <= '0;
      cnt_q     <= '0;
      wb_buf    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_al;
          wr_q    <= req_write;
          wdata_q <= req_wdata;
          be_q    <= req_be;
          way_q   <= victim_way;
          vtag_q  <= victim_tag;
          cnt_q   <= '0;
          if (in_window)                        state <= S_U_REQ;
          else if (victim_valid && victim_dirty) state <= S_WB_RD;
          else                                  state <= S_F_REQ;
        end
        S_WB_RD:  state <= S_WB_LAT;
        S_WB_LAT: begin
          wb_buf <= arr_rd_data;
          state  <= S_WB_SEND;
        end
        S_WB_SEND: if (mem_req_ready) begin
          cnt_q <= cnt_q + 1'b1;
          state <= (cnt_q == LAST) ? S_F_REQ : S_WB_RD;
        end
        S_F_REQ: if (mem_req_ready) state <= S_F_WAIT;
        S_F_WAIT: if (mem_rsp_valid) begin
          if (cnt_q == '0) begin
            rsp_valid <= 1'b1;
            rsp_data  <= arr_wr_data;
          end
          cnt_q <= cnt_q + 1'b1;
          state <= (cnt_q == LAST) ? S_TAG : S_F_REQ;
        end
        S_TAG: state <= S_IDLE;
        S_U_REQ: if (mem_req_ready) begin
          if (wr_q) begin
            rsp_valid <= 1'b1;
            rsp_data  <= '0;
            state     <= S_IDLE;
          end else begin
            state <= S_U_WAIT;
          end
        end
        S_U_WAIT: if (mem_rsp_valid) begin
          rsp_valid <= 1'b1;
          rsp_data  <= mem_rsp_data;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic          fill_started;
  logic          rsp_seen;
  logic          seen_fill;
  logic [WW-1:0] last_wr;
  logic [WW:0]   fills;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_started <= 1'b0;
      rsp_seen     <= 1'b0;
      seen_fill    <= 1'b0;
      last_wr      <= '0;
      fills        <= '0;
    end else if (state == S_IDLE && req_valid) begin
      fill_started <= 1'b0;
      rsp_seen     <= 1'b0;
      seen_fill    <= 1'b0;
      fills        <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready && !mem_req_write) fill_started <= 1'b1;
      if (rsp_valid) rsp_seen <= 1'b1;
      if (arr_wr_en) begin
        seen_fill <= 1'b1;
        last_wr   <= arr_wr_word;
        fills     <= fills + 1'b1;
      end
    end
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  assert_tag_ends_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tag_wr_en |=> !busy);

  assert_fill_wraps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_en && seen_fill |-> arr_wr_word == last_wr + 1'b1);

  assert_wb_before_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_started && mem_req_valid |-> !mem_req_write);

  assert_single_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !rsp_seen);

  assert_tag_after_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tag_wr_en |-> fills == (WW+1)'(WORDS));

endmodule

// File: tb/miss_fill_seq_bench.sv
`timescale 1ns/1ps
module miss_fill_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [3:0] req_be = 0;
  logic [2:0] victim_way = 0;
  logic victim_valid = 0, victim_dirty = 0;
  logic [20:0] victim_tag = 0;
  logic [31:0] nc_base = 32'h4000_0000, nc_limit = 32'h4000_1000;
  logic busy, rsp_valid;
  logic [31:0] rsp_data;
  logic [4:0] arr_set;
  logic [2:0] arr_way;
  logic arr_rd_en, arr_wr_en, tag_wr_en, tag_wr_dirty;
  logic [3:0] arr_rd_word, arr_wr_word;
  logic [31:0] arr_rd_data = 0, arr_wr_data;
  logic [20:0] tag_wr_tag;
  logic mem_req_valid, mem_req_write;
  logic mem_req_ready = 0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [3:0] mem_req_be;
  logic mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;

  miss_fill_seq u_miss_fill_seq (.*);

  int checks = 0, errors = 0;
  int cyc = 0, ready_mode = 0, pend = 0;
  logic [31:0] pend_addr = 0;

  int mn, an, tn, rn, hold_bad;
  logic [31:0] m_addr [64]; logic m_wr [64]; logic [31:0] m_data [64]; logic [3:0] m_be [64];
  logic [3:0] a_word [64]; logic [31:0] a_data [64]; logic [4:0] a_set [64]; logic [2:0] a_way [64];
  logic [20:0] t_tag; logic t_dirty; logic [31:0] r_data;
  logic hold_pend = 0; logic [31:0] hold_addr = 0;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction
  function automatic logic [31:0] vdat(input logic [4:0] s, input logic [3:0] w);
    return 32'hC0DE_0000 | {19'd0, s, 8'd0} | {28'd0, w};
  endfunction
  function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  always @(posedge clk) begin
    if (arr_rd_en) arr_rd_data <= vdat(arr_set, arr_rd_word);
    if (rst_n) begin
      if (hold_pend && !(mem_req_valid && mem_req_addr == hold_addr)) hold_bad++;
      hold_pend = mem_req_valid && !mem_req_ready;
      hold_addr = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        if (mn < 64) begin
          m_addr[mn] = mem_req_addr; m_wr[mn] = mem_req_write;
          m_data[mn] = mem_req_wdata; m_be[mn] = mem_req_be;
        end
        mn++;
        if (!mem_req_write) begin pend = 3; pend_addr = mem_req_addr; end
      end
      if (arr_wr_en) begin
        if (an < 64) begin
          a_word[an] = arr_wr_word; a_data[an] = arr_wr_data;
          a_set[an] = arr_set; a_way[an] = arr_way;
        end
        an++;
      end
      if (tag_wr_en) begin tn++; t_tag = tag_wr_tag; t_dirty = tag_wr_dirty; end
      if (rsp_valid) begin rn++; r_data = rsp_data; end
    end
  end

  always @(negedge clk) begin
    cyc++;
    mem_req_ready <= (ready_mode != 0) ? (cyc % 4 == 3) : 1'b1;
    if (pend > 0) begin
      pend--;
      if (pend == 1) begin mem_rsp_valid <= 1'b1; mem_rsp_data <= memf(pend_addr); end
      else mem_rsp_valid <= 1'b0;
    end else mem_rsp_valid <= 1'b0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic w, input logic [31:0] d,
                       input logic [3:0] be, input logic vv, input logic vd,
                       input logic [20:0] vt, input logic [2:0] way, input bit poke);
    @(negedge clk);
    mn = 0; an = 0; tn = 0; rn = 0; hold_bad = 0;
    req_valid = 1; req_addr = a; req_write = w; req_wdata = d; req_be = be;
    victim_valid = vv; victim_dirty = vd; victim_tag = vt; victim_way = way;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      req_valid = 1; req_addr = 32'h0000_2040; req_write = 1;
      @(negedge clk);
      req_valid = 0;
    end
    for (int t = 0; t < 3000 && busy; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!busy, "R2", "busy after completion", {31'd0, busy}, 0);
    chk(hold_bad == 0, "R10", "request dropped or changed while stalled", hold_bad, 0);
  endtask

  task automatic cached(input string name, input logic [31:0] a, input logic w,
                        input logic [31:0] d, input logic [3:0] be, input logic vv,
                        input logic vd, input logic [20:0] vt, input logic [2:0] way, input bit poke);
    logic [31:0] al = {a[31:2], 2'b00};
    logic [3:0] c = al[5:2];
    logic [4:0] s = al[10:6];
    int nw = (vv && vd) ? 16 : 0;
    logic [31:0] cw;
    issue(a, w, d, be, vv, vd, vt, way, poke);
    $display("scenario %s", name);
    chk(mn == nw + 16, (nw != 0) ? "R3" : "R4", "memory handshakes", mn, nw + 16);
    for (int k = 0; k < nw; k++) begin
      chk(m_wr[k] == 1 && m_addr[k] == {vt, s, 4'(k), 2'b00}, "R3", "writeback address",
          m_addr[k], {vt, s, 4'(k), 2'b00});
      chk(m_data[k] == vdat(s, 4'(k)), "R3", "writeback data", m_data[k], vdat(s, 4'(k)));
    end
    for (int k = 0; k < 16; k++) begin
      logic [3:0] wd = c + 4'(k);
      logic [31:0] ea = {al[31:6], wd, 2'b00};
      logic [31:0] ed = (k == 0 && w) ? mrg(memf(ea), d, be) : memf(ea);
      chk(m_wr[nw+k] == 0 && m_addr[nw+k] == ea, "R5", "fill read address", m_addr[nw+k], ea);
      chk(a_word[k] == wd && a_set[k] == s && a_way[k] == way, "R5", "array word/set/way",
          {a_word[k], 1'b0, a_set[k], 1'b0, a_way[k]}, {wd, 1'b0, s, 1'b0, way});
      chk(a_data[k] == ed, (k == 0 && w) ? "R7" : "R5", "array data", a_data[k], ed);
    end
    chk(an == 16, "R5", "array write count", an, 16);
    cw = {al[31:6], c, 2'b00};
    cw = w ? mrg(memf(cw), d, be) : memf(cw);
    chk(rn == 1, "R6", "response pulses", rn, 1);
    chk(r_data == cw, w ? "R7" : "R6", "critical word response", r_data, cw);
    chk(tn == 1 && t_tag == al[31:11], "R8", "tag update", {11'd0, t_tag}, {11'd0, al[31:11]});
    chk(t_dirty == w, "R8", "dirty bit", {31'd0, t_dirty}, {31'd0, w});
  endtask

  task automatic uncached(input string name, input logic [31:0] a, input logic w,
                          input logic [31:0] d, input logic [3:0] be);
    logic [31:0] al = {a[31:2], 2'b00};
    issue(a, w, d, be, 1, 1, 21'h1, 3'd2, 0);
    $display("scenario %s", name);
    chk(mn == 1, "R9", "uncached handshake count", mn, 1);
    chk(m_addr[0] == al && m_wr[0] == w, "R11", "uncached aligned address", m_addr[0], al);
    if (w) chk(m_data[0] == d && m_be[0] == be, "R9", "uncached store data", m_data[0], d);
    chk(an == 0 && tn == 0, "R9", "no array or tag writes", an + tn, 0);
    chk(rn == 1, "R9", "uncached response count", rn, 1);
    chk(r_data == (w ? 32'd0 : memf(al)), "R9", "uncached response data", r_data,
        w ? 32'd0 : memf(al));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req_valid && !rsp_valid && !arr_wr_en && !tag_wr_en, "R1",
        "outputs in reset", {27'd0, busy, mem_req_valid, rsp_valid, arr_wr_en, tag_wr_en}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy && !mem_req_valid, "R1", "idle after reset", {30'd0, busy, mem_req_valid}, 0);

    cached("load clean crit0", 32'h1234_5640, 0, 0, 4'h0, 1, 0, 21'h0ABCD, 3'd1, 0);
    cached("load dirty crit5 R3", 32'h0765_4354, 0, 0, 4'h0, 1, 1, 21'h1F00F, 3'd6, 0);
    cached("store invalid-dirty crit15 unaligned R4 R11", 32'h2000_07FF, 1,
           32'hAABB_CCDD, 4'b0101, 0, 1, 21'h15555, 3'd3, 0);
    ready_mode = 1;
    cached("store dirty crit9 slow memory", 32'h8000_0AA4, 1, 32'h1122_3344, 4'b1001,
           1, 1, 21'h00042, 3'd7, 0);
    ready_mode = 0;
    cached("request while busy ignored R2", 32'h0000_0C08, 0, 0, 4'h0, 1, 0, 21'h3, 3'd0, 1);
    uncached("uncached load at base", 32'h4000_0000, 0, 0, 4'h0);
    uncached("uncached store below limit", 32'h4000_0FFE, 1, 32'hDEAD_BEEF, 4'b0110);
    cached("at limit is cached", 32'h4000_1000, 0, 0, 4'h0, 1, 0, 21'h7, 3'd4, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule